// File: doc/BRIEF.md
# Compare Match Output Pin Unit

This block sits between one compare channel of a timer and one device pin. It holds a single output flip-flop, the compare state. The counter reports compare-match and TOP events. A software force strobe can also arrive. For each event the block sets, clears or toggles the compare state, as chosen by a two-bit output mode field and by the current waveform class, which is either non-PWM or fast PWM.

When the output mode field is nonzero, the compare state replaces the general port data value on the pin. The pin direction always comes from the port direction bit. The compare state can be preset while the pin is still under port control, so the waveform starts from a known level when the override is turned on. Changing the mode field alone never moves the compare state. The new mode is applied at the next event.

Top module: `cmp_pin_unit`

## Requirements
- R1: When mode_i is nonzero, pin_o equals the compare state (cmp_state_o) in the same cycle.
- R2: When mode_i is 0, pin_o equals port_data_i in the same cycle.
- R3: pin_oe_o always equals port_dir_i, whatever the mode.
- R4: With mode_i = 0, match_i, top_i and force_i leave the compare state unchanged.
- R5: With pwm_i = 0, a cycle with match_i high changes the compare state at the next clock edge: mode 1 toggles it, mode 2 clears it, and mode 3 sets it.
- R6: With pwm_i = 0, force_i applies the same action as a match at the next edge. When force_i and match_i are both high in one cycle, the action is applied only once, so mode 1 toggles a single time.
- R7: With pwm_i = 1 and mode 2, match_i sets the compare state and top_i clears it. With mode 3, match_i clears it and top_i sets it. When match_i and top_i are both high, the TOP action wins.
- R8: With pwm_i = 1, force_i has no effect and mode 1 takes no action. With pwm_i = 0, top_i has no effect.
- R9: preset_we_i loads preset_val_i into the compare state at the next edge. It takes priority over every event in the same cycle and works whatever the mode.
- R10: After reset the compare state is 0.
- R11: Writing a new mode_i value without any event leaves the compare state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Output mode field (0 none, 1 toggle, 2, 3) |
| pwm_i | input | 1 | Waveform class: 1 = fast PWM, 0 = non-PWM |
| match_i | input | 1 | Compare-match event from the counter |
| top_i | input | 1 | Counter-at-TOP event |
| force_i | input | 1 | Single-cycle force strobe |
| preset_we_i | input | 1 | Load strobe for the compare state |
| preset_val_i | input | 1 | Value loaded by preset_we_i |
| port_data_i | input | 1 | General port data bit for the pin |
| port_dir_i | input | 1 | Port direction bit (1 = output) |
| pin_o | output | 1 | Value driven toward the pin |
| pin_oe_o | output | 1 | Pin output enable |
| cmp_state_o | output | 1 | Current compare state |

## Verification
Random cycles mix all modes, both waveform classes and arbitrary overlaps of match, TOP, force and preset. A bench model of the next state checks each cycle. This separates the action table of each waveform class and exposes wrong event priority.

Directed sequences cover the remaining corner cases:
- A force coinciding with a match in toggle mode, which shows a double toggle.
- Match and TOP in the same PWM cycle, which shows the wrong winner.
- A mode write with no event, which shows an early mode application.
- A preset made while the override is off, then made visible by turning the override on.

// File: rtl/cmp_pin_pkg.sv
package cmp_pin_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } cmp_act_e;

  localparam logic [1:0] MODE_OFF = 2'd0;
  localparam logic [1:0] MODE_TGL = 2'd1;
  localparam logic [1:0] MODE_NRM = 2'd2;
  localparam logic [1:0] MODE_INV = 2'd3;
endpackage

// File: rtl/cmp_act_dec.sv
module cmp_act_dec
  import cmp_pin_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       pwm_i,
  input  logic       match_i,
  input  logic       top_i,
  input  logic       force_i,
  output cmp_act_e   act_o
);
  logic np_evt;
  assign np_evt = match_i | force_i;  // force and match merge into one action

  always_comb begin
    act_o = ACT_NONE;
    if (pwm_i) begin
      unique case (mode_i)
        MODE_NRM: if (top_i) act_o = ACT_CLR; else if (match_i) act_o = ACT_SET;
        MODE_INV: if (top_i) act_o = ACT_SET; else if (match_i) act_o = ACT_CLR;
        default:  act_o = ACT_NONE;
      endcase
    end else if (np_evt) begin
      unique case (mode_i)
        MODE_TGL: act_o = ACT_TGL;
        MODE_NRM: act_o = ACT_CLR;
        MODE_INV: act_o = ACT_SET;
        default:  act_o = ACT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cmp_state_reg.sv
module cmp_state_reg
  import cmp_pin_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  cmp_act_e act_i,
  input  logic     preset_we_i,
  input  logic     preset_val_i,
  output logic     state_o
);
  logic state_d;

  always_comb begin
    state_d = state_o;
    if (preset_we_i) state_d = preset_val_i;
    else begin
      unique case (act_i)
        ACT_SET: state_d = 1'b1;
        ACT_CLR: state_d = 1'b0;
        ACT_TGL: state_d = ~state_o;
        default: state_d = state_o;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= 1'b0;
    else         state_o <= state_d;
  end
endmodule

// File: rtl/cmp_pin_mux.sv
module cmp_pin_mux (
  input  logic [1:0] mode_i,
  input  logic       state_i,
  input  logic       port_data_i,
  input  logic       port_dir_i,
  output logic       pin_o,
  output logic       pin_oe_o
);
  logic ovr;
  assign ovr      = |mode_i;
  assign pin_o    = ovr ? state_i : port_data_i;
  assign pin_oe_o = port_dir_i;
endmodule

// File: rtl/cmp_pin_unit.sv
module cmp_pin_unit
  import cmp_pin_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       pwm_i,
  input  logic       match_i,
  input  logic       top_i,
  input  logic       force_i,
  input  logic       preset_we_i,
  input  logic       preset_val_i,
  input  logic       port_data_i,
  input  logic       port_dir_i,
  output logic       pin_o,
  output logic       pin_oe_o,
  output logic       cmp_state_o
);
  cmp_act_e act;

  cmp_act_dec u_dec (
    .mode_i (mode_i),
    .pwm_i  (pwm_i),
    .match_i(match_i),
    .top_i  (top_i),
    .force_i(force_i),
    .act_o  (act)
  );

  cmp_state_reg u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act),
    .preset_we_i (preset_we_i),
    .preset_val_i(preset_val_i),
    .state_o     (cmp_state_o)
  );

  cmp_pin_mux u_mux (
    .mode_i     (mode_i),
    .state_i    (cmp_state_o),
    .port_data_i(port_data_i),
    .port_dir_i (port_dir_i),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o)
  );
endmodule

// File: rtl/cmp_pin_unit_chk.sv
module cmp_pin_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       pwm_i,
  input logic       match_i,
  input logic       top_i,
  input logic       force_i,
  input logic       preset_we_i,
  input logic       preset_val_i,
  input logic       port_data_i,
  input logic       port_dir_i,
  input logic       pin_o,
  input logic       pin_oe_o,
  input logic       cmp_state_o
);
  a_r1_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd0) |-> (pin_o == cmp_state_o));

  a_r2_port_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0) |-> (pin_o == port_data_i));

  a_r3_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o == port_dir_i);

  a_r4_off_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && !preset_we_i) |=> $stable(cmp_state_o));

  a_r5_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwm_i && mode_i == 2'd1 && match_i && !preset_we_i) |=> (cmp_state_o != $past(cmp_state_o)));

  a_r7_top_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_i && mode_i == 2'd2 && top_i && !preset_we_i) |=> !cmp_state_o);

  a_r8_pwm_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_i && !match_i && !top_i && !preset_we_i) |=> $stable(cmp_state_o));

  a_r9_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_we_i |=> (cmp_state_o == $past(preset_val_i)));
endmodule

bind cmp_pin_unit cmp_pin_unit_chk u_chk (.*);

// File: tb/cmp_pin_unit_test.sv
module cmp_pin_unit_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = '0;
  logic       pwm_i = 0, match_i = 0, top_i = 0, force_i = 0;
  logic       preset_we_i = 0, preset_val_i = 0, port_data_i = 0, port_dir_i = 0;
  logic       pin_o, pin_oe_o, cmp_state_o;

  int checks = 0, errors = 0;
  logic exp_state = 1'b0;

  always #4 clk_i = ~clk_i;

  cmp_pin_unit uut (.*);

  function automatic logic model_next(logic [1:0] m, logic p, logic mt, logic tp,
                                      logic fc, logic pw, logic pv, logic cur);
    if (pw) return pv;
    if (p) begin
      if (m == 2'd2) return tp ? 1'b0 : (mt ? 1'b1 : cur);
      if (m == 2'd3) return tp ? 1'b1 : (mt ? 1'b0 : cur);
      return cur;
    end
    if (!(mt || fc)) return cur;
    case (m)
      2'd1: return ~cur;
      2'd2: return 1'b0;
      2'd3: return 1'b1;
      default: return cur;
    endcase
  endfunction

  function automatic string tag_of();
    if (preset_we_i) return "R9";
    if (mode_i == 2'd0) return "R4";
    if (pwm_i) return (force_i && !match_i && !top_i) ? "R8" : "R7";
    if (top_i && !match_i && !force_i) return "R8";
    return force_i ? "R6" : "R5";
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(logic [1:0] m, logic p, logic mt, logic tp, logic fc,
                      logic pw, logic pv, logic pd, logic dir);
    string t;
    logic nxt;
    mode_i = m; pwm_i = p; match_i = mt; top_i = tp; force_i = fc;
    preset_we_i = pw; preset_val_i = pv; port_data_i = pd; port_dir_i = dir;
    #1;
    if (m != 2'd0) chk("R1", pin_o, exp_state);
    else           chk("R2", pin_o, pd);
    chk("R3", pin_oe_o, dir);
    t = tag_of();
    nxt = model_next(m, p, mt, tp, fc, pw, pv, exp_state);
    @(posedge clk_i);
    @(negedge clk_i);
    force_i = 1'b0;
    chk(t, cmp_state_o, nxt);
    exp_state = nxt;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk("R10", cmp_state_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10", cmp_state_o, 1'b0);
    // R9: preset while override off, then reveal
    step(2'd0, 0, 0, 0, 0, 1, 1, 0, 1);
    step(2'd0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R9", pin_o, 1'b0);
    mode_i = 2'd3; #1;
    chk("R9", pin_o, 1'b1);
    // R11: mode writes without events leave state
    step(2'd1, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R11", cmp_state_o, 1'b1);
    step(2'd2, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R11", cmp_state_o, 1'b1);
    // R6: force + match in toggle mode = one toggle
    step(2'd1, 0, 1, 0, 1, 0, 0, 0, 1);
    chk("R6", cmp_state_o, 1'b0);
    // R5: clear and set
    step(2'd3, 0, 1, 0, 0, 0, 0, 0, 1);
    step(2'd2, 0, 1, 0, 0, 0, 0, 0, 1);
    // R7: match and top together, TOP wins
    step(2'd2, 1, 1, 1, 0, 0, 0, 0, 1);
    chk("R7", cmp_state_o, 1'b0);
    step(2'd3, 1, 1, 1, 0, 0, 0, 0, 1);
    chk("R7", cmp_state_o, 1'b1);
    // R8: mode 1 in PWM, force in PWM
    step(2'd1, 1, 1, 1, 1, 0, 0, 0, 1);
    chk("R8", cmp_state_o, 1'b1);
    step(2'd2, 1, 0, 0, 1, 0, 0, 1, 0);
    chk("R8", cmp_state_o, 1'b1);
    // R4: mode 0 ignores events
    step(2'd0, 0, 1, 1, 1, 0, 0, 1, 1);
    chk("R4", cmp_state_o, 1'b1);
    // R9: preset beats events
    step(2'd1, 0, 1, 0, 1, 1, 1, 0, 1);
    chk("R9", cmp_state_o, 1'b1);
    for (int i = 0; i < 3000; i++) begin
      step(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), ($urandom % 8) == 0, 1'($urandom), 1'($urandom), 1'($urandom));
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule